// File: doc/BRIEF.md
# Two-Channel Aligned Stream Launcher

This block sits between two sample sources and two output channels. Each channel repeats every sample for a number of clock cycles set by its own interpolation factor, so the two channels may run at very different output rates. The block decides when each channel starts to emit. Samples are pulled from each source with a read-enable request and are presented on a held output with a one-cycle strobe.

A two-bit control word drives the block. Bit 0 pauses both channels. Bit 1 selects the aligned start. In aligned mode, clearing the pause bit does not start output at once. Each channel first asks for one word and keeps it. The channels then launch on the same clock, and both interpolation counters restart from zero. The phase between the two channels is therefore the same on every start, however long either source took to deliver its first word. With bit 1 cleared, each channel launches on its own as soon as it holds a word.

Top module: `dual_stream_sync_start`

## Requirements
- R1: While reset is applied, both outputs and both strobes are zero. After reset with the pause bit (control bit 0) set, both read enables are low.
- R2: While the pause bit is set, both read enables are low, both strobes are low one cycle later, and both outputs keep their values.
- R3: After the pause bit clears, an idle channel holds its read enable high until it accepts a word (read enable and valid high at the same edge). It then drops the read enable until it launches.
- R4: With the aligned bit (control bit 1) set, neither channel strobes until both have accepted a word. Both channels then give their first strobe in the same cycle, two cycles after the later channel's accepting edge.
- R5: A running channel with factor F gives one strobe every F cycles after its first strobe. A factor of 0 acts as 1, which gives a strobe on every cycle.
- R6: At launch each interpolation counter restarts from zero. The strobe pattern after a launch depends only on the launch cycle and F, and not on the counter state before the pause.
- R7: With the aligned bit cleared, each channel gives its first strobe two cycles after its own accepting edge, whatever the other channel does.
- R8: Setting the pause bit again and clearing it runs the whole arming sequence again, with the requests, the wait and the launch.
- R9: Each channel presents its accepted words in order. The first strobe carries the word taken while arming, and every later strobe carries the word accepted at the slot before it.
- R10: If a running channel finds valid low at a sample slot, it gives no strobe and its output holds. The next slot follows F cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 2 | Bit 0 pauses both channels, bit 1 selects the aligned start |
| factor_a | input | FW | Interpolation factor of channel A |
| factor_b | input | FW | Interpolation factor of channel B |
| a_valid | input | 1 | Channel A source word valid |
| a_data | input | DW | Channel A source word |
| a_rd_en | output | 1 | Channel A read request |
| b_valid | input | 1 | Channel B source word valid |
| b_data | input | DW | Channel B source word |
| b_rd_en | output | 1 | Channel B read request |
| a_out | output | DW | Channel A held sample |
| a_strobe | output | 1 | Channel A new-sample pulse |
| b_out | output | DW | Channel B held sample |
| b_strobe | output | 1 | Channel B new-sample pulse |

## Verification
The bench builds the block with its default widths: 16-bit data and 8-bit factors. It drives factors from 0 to 5, so it reaches the zero-as-one case, factor 1 against a slower partner, and equal and unequal factor pairs. It varies the delay before each source offers data, so either channel can be the late one in aligned mode. One case stops a source after its first word, which reaches the missed-slot path.

// File: rtl/dual_stream_sync_start.sv
module dual_stream_sync_start #(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ctrl,
  input  logic [FW-1:0] factor_a,
  input  logic [FW-1:0] factor_b,
  input  logic          a_valid,
  input  logic [DW-1:0] a_data,
  output logic          a_rd_en,
  input  logic          b_valid,
  input  logic [DW-1:0] b_data,
  output logic          b_rd_en,
  output logic [DW-1:0] a_out,
  output logic          a_strobe,
  output logic [DW-1:0] b_out,
  output logic          b_strobe
);
  localparam int CH = 2;

  wire suspend = ctrl[0];
  wire sync_en = ctrl[1];

  logic [FW-1:0] fac [CH];
  logic [FW-1:0] last [CH];
  logic [FW-1:0] cnt [CH];
  logic [DW-1:0] din [CH];
  logic [DW-1:0] pend [CH];
  logic [DW-1:0] dout [CH];
  logic [CH-1:0] vin, have, run, strb, rd, rel;

  assign fac[0] = factor_a;
  assign fac[1] = factor_b;
  assign din[0] = a_data;
  assign din[1] = b_data;
  assign vin    = {b_valid, a_valid};

  always_comb begin
    for (int i = 0; i < CH; i++) begin
      last[i] = (fac[i] == '0) ? '0 : fac[i] - 1'b1;
      rd[i]   = !suspend && (run[i] ? (cnt[i] == last[i]) : !have[i]);
      rel[i]  = !suspend && !run[i] && (sync_en ? &have : have[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= '0;
      have <= '0;
      strb <= '0;
      for (int i = 0; i < CH; i++) begin
        cnt[i]  <= '0;
        pend[i] <= '0;
        dout[i] <= '0;
      end
    end else begin
      for (int i = 0; i < CH; i++) begin
        strb[i] <= 1'b0;
        if (suspend) begin
          run[i]  <= 1'b0;
          have[i] <= 1'b0;
          cnt[i]  <= '0;
        end else if (rel[i]) begin
          run[i]  <= 1'b1;
          have[i] <= 1'b0;
          cnt[i]  <= '0;
          dout[i] <= pend[i];
          strb[i] <= 1'b1;
        end else if (run[i]) begin
          if (cnt[i] == last[i]) begin
            cnt[i] <= '0;
            if (vin[i]) begin
              dout[i] <= din[i];
              strb[i] <= 1'b1;
            end
          end else begin
            cnt[i] <= cnt[i] + 1'b1;
          end
        end else if (rd[i] && vin[i]) begin
          pend[i] <= din[i];
          have[i] <= 1'b1;
        end
      end
    end
  end

  assign a_rd_en  = rd[0];
  assign b_rd_en  = rd[1];
  assign a_out    = dout[0];
  assign b_out    = dout[1];
  assign a_strobe = strb[0];
  assign b_strobe = strb[1];

  a_r2_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> (!a_strobe && !b_strobe));
  a_r4_joint_launch: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run[0]) && $past(sync_en && !suspend)) |-> $rose(run[1]));
  a_r3_accept_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(have[0]) |-> $past(a_rd_en && a_valid));
  a_r5_strobe_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    (a_strobe || b_strobe) |-> ((!a_strobe || run[0]) && (!b_strobe || run[1])));
  a_r10_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    !a_strobe |-> $stable(a_out));
  a_r10_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    !b_strobe |-> $stable(b_out));
endmodule

// File: tb/dual_stream_sync_start_bench.sv
module dual_stream_sync_start_bench;
  localparam int DW = 16;
  localparam int FW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ctrl = 2'b01;
  logic [FW-1:0] factor_a = '0, factor_b = '0;
  logic a_valid = 1'b0, b_valid = 1'b0;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic a_rd_en, b_rd_en, a_strobe, b_strobe;
  logic [DW-1:0] a_out, b_out;

  always #2.5 clk = ~clk;

  dual_stream_sync_start #(.DW(DW), .FW(FW)) u_dual_stream_sync_start (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
    .factor_a(factor_a), .factor_b(factor_b),
    .a_valid(a_valid), .a_data(a_data), .a_rd_en(a_rd_en),
    .b_valid(b_valid), .b_data(b_data), .b_rd_en(b_rd_en),
    .a_out(a_out), .a_strobe(a_strobe), .b_out(b_out), .b_strobe(b_strobe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cons_a = 0, cons_b = 0;

  // columns: aligned, factor A, factor B, delay A, delay B, stop A after first word
  localparam int NC = 7;
  localparam logic [5:0][7:0] CASES [NC] = '{
    '{8'd1, 8'd1, 8'd3, 8'd0, 8'd4, 8'd0},
    '{8'd1, 8'd4, 8'd2, 8'd5, 8'd1, 8'd0},
    '{8'd1, 8'd3, 8'd3, 8'd2, 8'd2, 8'd0},
    '{8'd0, 8'd2, 8'd3, 8'd1, 8'd6, 8'd0},
    '{8'd0, 8'd1, 8'd1, 8'd3, 8'd0, 8'd0},
    '{8'd1, 8'd0, 8'd5, 8'd3, 8'd3, 8'd0},
    '{8'd0, 8'd2, 8'd1, 8'd0, 8'd2, 8'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_case(input int sync, input int fa, input int fb,
                          input int da, input int db, input int stop_a);
    logic [DW-1:0] hold_a, hold_b;
    int ea, eb, s0a, s0b, sa, sb, n, ta;
    bit ra, rb;
    // R2 / R8: pause, outputs frozen
    @(negedge clk);
    ctrl = 2'b01; a_valid = 1'b0; b_valid = 1'b0;
    hold_a = a_out; hold_b = b_out;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!a_strobe && !b_strobe, "R2 strobes while paused", {a_strobe, b_strobe}, 0);
      chk(a_out == hold_a && b_out == hold_b, "R2 outputs held while paused", a_out, hold_a);
      chk(!a_rd_en && !b_rd_en, "R2 requests while paused", {a_rd_en, b_rd_en}, 0);
    end
    factor_a = FW'(fa); factor_b = FW'(fb);
    ea = (fa == 0) ? 1 : fa;
    eb = (fb == 0) ? 1 : fb;
    sa = cons_a; sb = cons_b;
    ta = -1;
    s0a = (sync != 0) ? ((da > db ? da : db) + 2) : da + 2;
    s0b = (sync != 0) ? s0a : db + 2;
    n = (s0a > s0b ? s0a : s0b) + 22;
    for (int t = 0; t < n; t++) begin
      if (t > 0) @(negedge clk);
      // outputs reflect edges up to t-1
      begin
        bit xa, xb;
        if (stop_a != 0) xa = (t == s0a);
        else xa = (t >= s0a) && ((t - s0a) % ea == 0);
        xb = (t >= s0b) && ((t - s0b) % eb == 0);
        chk(a_strobe == xa, (sync != 0) ? "R4 R5 R6 strobe A" :
                            (stop_a != 0) ? "R10 R7 strobe A" : "R7 R5 strobe A", a_strobe, xa);
        chk(b_strobe == xb, (sync != 0) ? "R4 R5 R6 strobe B" : "R7 R5 strobe B", b_strobe, xb);
        if (t >= s0a) begin
          int ka = (stop_a != 0) ? 0 : (t - s0a) / ea;
          chk(a_out == DW'(16'hA000 + sa + ka), "R9 R10 data A", a_out, 16'hA000 + sa + ka);
        end
        if (t >= s0b)
          chk(b_out == DW'(16'hB000 + sb + (t - s0b) / eb), "R9 data B", b_out,
              16'hB000 + sb + (t - s0b) / eb);
      end
      ctrl = {sync[0], 1'b0};
      a_valid = (t >= da) && !(stop_a != 0 && cons_a > sa);
      b_valid = (t >= db);
      a_data = DW'(16'hA000 + cons_a);
      b_data = DW'(16'hB000 + cons_b);
      #1;
      if (t <= da) chk(a_rd_en, "R3 R8 arm request A", a_rd_en, 1);
      else if (t < s0a) chk(!a_rd_en, "R3 R4 request A after accept", a_rd_en, 0);
      if (t <= db) chk(b_rd_en, "R3 R8 arm request B", b_rd_en, 1);
      else if (t < s0b) chk(!b_rd_en, "R3 R4 request B after accept", b_rd_en, 0);
      ra = a_rd_en && a_valid;
      rb = b_rd_en && b_valid;
      @(posedge clk);
      if (ra) cons_a++;
      if (rb) cons_b++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!a_strobe && !b_strobe, "R1 strobes in reset", {a_strobe, b_strobe}, 0);
    chk(a_out == '0 && b_out == '0, "R1 outputs in reset", a_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!a_rd_en && !b_rd_en, "R1 requests after reset", {a_rd_en, b_rd_en}, 0);
    for (int c = 0; c < NC; c++)
      run_case(CASES[c][5], CASES[c][4], CASES[c][3], CASES[c][2], CASES[c][1], CASES[c][0]);
    // R8: repeat an aligned case right after an independent one
    run_case(1, 2, 5, 4, 0, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule